// File: doc/BRIEF.md
# Serial Successive-Approximation Conversion Sequencer

This block is the digital heart of an 8-bit successive-approximation converter that is read over a synchronous serial link. A host lowers the active-low select, toggles the serial clock and, on rising edges, sends a start bit of 1 followed by two channel-address bits on the data input. The block then runs a bit-by-bit search. In each trial it sets one candidate bit of the DAC code and keeps or drops that bit according to a one-bit comparator result. Each bit is sent back on the data output as soon as it is decided.

After the most-significant-first stream ends, the block sends the stored result again from the least-significant end. The LSB is shared by both streams, so the host sees a leading 0 and then 15 data bits. The output is tri-statable. It stays released whenever the data input is being sampled, so both pins can share one bidirectional wire.

All timing follows serial-clock edges. The block detects these edges in its own system clock, which must be several times faster than the serial clock. The analogue ladder, the comparator and the reference are outside the block.

Top module: `sar_serial_seq`

## Requirements
- R1: After reset, and whenever select is high, `do_oe`=0, `dac_code`=0 and `mux_sel`=0. A conversion starts only after select has been seen high and then low. If select is already low when reset ends, serial activity is ignored.
- R2: While waiting for the start bit, a rising serial-clock edge with `di`=0 is ignored. The first rising edge with `di`=1 is taken as the start bit.
- R3: The next two rising edges after the start bit sample the address, first bit into `mux_sel[1]` and second into `mux_sel[0]`. `mux_sel` changes at the second address edge and stays stable until select goes high.
- R4: On the first falling edge after the address is complete, the block does three things: it sets `dac_code` to 8'h80, enables `do_oe`, and drives `do_out`=0 as the leading bit.
- R5: On each of the next 8 falling edges, the current trial bit is kept if `cmp_hi`=1 and cleared otherwise. The next lower bit is then set as the new trial, and bits below it are 0. After the eighth decision, `dac_code` holds the final result.
- R6: On falling edges 1 to 8 after the leading bit, `do_out` carries result bits 7 down to 0, in that order.
- R7: On falling edges 9 to 15, `do_out` carries result bits 1 up to 7. The LSB is not repeated. On falling edge 16, `do_oe` returns to 0.
- R8: `do_oe` stays 0 while the block waits for the start bit and while it receives the address bits.
- R9: With select held low after a conversion ends, further serial clocking starts nothing. `do_oe` stays 0 and `dac_code` keeps the result.
- R10: Raising select at any point, including in mid-conversion, clears `dac_code`, `mux_sel` and `do_oe`. A later select fall runs a fresh, correct conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; serial edges are detected in this domain |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select; high clears the block |
| sclk | input | 1 | Serial clock from the host, synchronous to clk |
| di | input | 1 | Serial data in (start bit, address bits) |
| cmp_hi | input | 1 | Comparator: 1 keeps the current trial bit |
| do_out | output | 1 | Serial data out value |
| do_oe | output | 1 | Output enable for the data out driver |
| mux_sel | output | 2 | Channel configuration chosen by the address bits |
| dac_code | output | 8 | Code driven to the external DAC/comparator |

## Verification
The eighth decision of the search and the loading of the LSB-first shift register occur on the same falling edge. That edge also decides whether the shared LSB is sent once or twice, and which stored bits the reverse stream begins with. The bench sweeps every analogue level from 0 to 255, so every pattern of bit 0 against bit 1 appears at that edge. It compares all 15 streamed bits, plus the release that follows, against the binary expansion of the level.

A second coincidence is a select rise during the search while a trial is pending. This is provoked by an abort after three decisions, and it is judged by the cleared outputs and by a correct conversion that follows.

// File: rtl/sarseq_pkg.sv
package sarseq_pkg;
  typedef enum logic [2:0] {
    ST_LOCK,
    ST_IDLE,
    ST_HUNT,
    ST_ADDR,
    ST_SETTLE,
    ST_MSB,
    ST_LSB,
    ST_DONE
  } seq_st_e;
endpackage

// File: rtl/sclk_edge_det.sv
module sclk_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  output logic rise,
  output logic fall
);
  logic sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk;
  end

  assign rise = sclk & ~sclk_q;
  assign fall = ~sclk & sclk_q;
endmodule

// File: rtl/sar_search_reg.sv
module sar_search_reg #(
  parameter int RES_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             begin_s,
  input  logic             step,
  input  logic             cmp_hi,
  output logic             last,
  output logic [RES_W-1:0] code
);
  localparam int IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1;

  logic [IDX_W-1:0] idx;
  logic [RES_W-1:0] code_nxt;

  // keep/drop current trial, arm the next lower one
  always_comb begin
    code_nxt = code;
    code_nxt[idx] = cmp_hi;
    if (idx != '0) code_nxt[idx - 1'b1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code <= '0;
      idx  <= '0;
    end else if (clr) begin
      code <= '0;
      idx  <= '0;
    end else if (begin_s) begin
      code <= {1'b1, {(RES_W-1){1'b0}}};
      idx  <= IDX_W'(RES_W-1);
    end else if (step) begin
      code <= code_nxt;
      if (idx != '0) idx <= idx - 1'b1;
    end
  end

  assign last = (idx == '0);

  a_r4_first_trial: assert property (@(posedge clk) disable iff (!rst_n || clr)
    begin_s |=> (code[RES_W-1] && $onehot(code)));

  a_r5_next_trial: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (step && idx != '0) |=> code[$past(idx) - 1'b1]);

  a_r5_upper_kept: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (step && idx != '0 && idx != IDX_W'(RES_W-1)) |=> (code[RES_W-1] == $past(code[RES_W-1])));
endmodule

// File: rtl/result_serializer.sv
module result_serializer #(
  parameter int RES_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             drive_on,
  input  logic             msb_bit,
  input  logic             bit_val,
  input  logic             load,
  input  logic [RES_W-2:0] upper,
  input  logic             shift,
  output logic             empty,
  output logic             do_out,
  output logic             do_oe
);
  localparam int CNT_W = (RES_W > 1) ? $clog2(RES_W) : 1;

  logic [RES_W-2:0] shreg;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0; cnt <= '0; do_out <= 1'b0; do_oe <= 1'b0;
    end else if (clr) begin
      shreg <= '0; cnt <= '0; do_out <= 1'b0; do_oe <= 1'b0;
    end else begin
      if (drive_on) begin
        do_oe  <= 1'b1;
        do_out <= 1'b0;
      end
      if (msb_bit) do_out <= bit_val;
      if (load) begin
        shreg <= upper;
        cnt   <= CNT_W'(RES_W-1);
      end
      if (shift) begin
        if (cnt != '0) begin
          do_out <= shreg[0];
          shreg  <= shreg >> 1;
          cnt    <= cnt - 1'b1;
        end else begin
          do_oe  <= 1'b0;
          do_out <= 1'b0;
        end
      end
    end
  end

  assign empty = (cnt == '0);

  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (shift && empty) |=> !do_oe);

  a_r7_lsb_stream: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (shift && !empty) |=> (do_oe && do_out == $past(shreg[0])));
endmodule

// File: rtl/sar_serial_seq.sv
module sar_serial_seq #(
  parameter int RES_W  = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              di,
  input  logic              cmp_hi,
  output logic              do_out,
  output logic              do_oe,
  output logic [ADDR_W-1:0] mux_sel,
  output logic [RES_W-1:0]  dac_code
);
  import sarseq_pkg::*;

  localparam int ACNT_W = (ADDR_W > 1) ? $clog2(ADDR_W) : 1;

  seq_st_e           st;
  logic [ACNT_W-1:0] acnt;
  logic [ADDR_W-1:0] addr_sh;
  logic              rise, fall;
  logic              sar_begin, sar_step, sar_last;
  logic              ser_shift, ser_empty;

  sclk_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .rise(rise), .fall(fall)
  );

  assign sar_begin = (st == ST_SETTLE) && fall;
  assign sar_step  = (st == ST_MSB) && fall;
  assign ser_shift = (st == ST_LSB) && fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_LOCK; acnt <= '0; addr_sh <= '0; mux_sel <= '0;
    end else if (cs_n) begin
      st <= ST_IDLE; acnt <= '0; addr_sh <= '0; mux_sel <= '0;
    end else begin
      unique case (st)
        ST_IDLE: st <= ST_HUNT;
        ST_HUNT: if (rise && di) begin
          st   <= ST_ADDR;
          acnt <= '0;
        end
        ST_ADDR: if (rise) begin
          addr_sh <= {addr_sh[ADDR_W-2:0], di};
          if (acnt == ACNT_W'(ADDR_W-1)) begin
            mux_sel <= {addr_sh[ADDR_W-2:0], di};
            st      <= ST_SETTLE;
          end else begin
            acnt <= acnt + 1'b1;
          end
        end
        ST_SETTLE: if (fall) st <= ST_MSB;
        ST_MSB:    if (fall && sar_last) st <= ST_LSB;
        ST_LSB:    if (fall && ser_empty) st <= ST_DONE;
        default:   st <= st;  // LOCK and DONE wait for select high
      endcase
    end
  end

  sar_search_reg #(.RES_W(RES_W)) u_sar (
    .clk(clk), .rst_n(rst_n), .clr(cs_n),
    .begin_s(sar_begin), .step(sar_step), .cmp_hi(cmp_hi),
    .last(sar_last), .code(dac_code)
  );

  result_serializer #(.RES_W(RES_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .clr(cs_n),
    .drive_on(sar_begin), .msb_bit(sar_step), .bit_val(cmp_hi),
    .load(sar_step && sar_last), .upper(dac_code[RES_W-1:1]),
    .shift(ser_shift), .empty(ser_empty),
    .do_out(do_out), .do_oe(do_oe)
  );

  a_r8_quiet_while_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HUNT || st == ST_ADDR || st == ST_SETTLE) |-> !do_oe);

  a_r3_mux_hold: assert property (@(posedge clk) disable iff (!rst_n || cs_n)
    ((st == ST_MSB || st == ST_LSB || st == ST_DONE) && $past(st) != ST_ADDR
      && $past(st) != ST_IDLE) |-> $stable(mux_sel));

  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (!do_oe && dac_code == '0 && mux_sel == '0));

  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n || cs_n)
    (st == ST_DONE) |=> (!do_oe && $stable(dac_code)));

  a_r1_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LOCK) |-> (!do_oe && dac_code == '0));
endmodule

// File: tb/sim_sar_serial_seq.sv
module sim_sar_serial_seq;
  localparam int H = 4;

  logic       clk = 1'b0;
  logic       rst_n, cs_n, sclk, di, cmp_hi;
  logic       do_out, do_oe;
  logic [1:0] mux_sel;
  logic [7:0] dac_code;
  logic [7:0] level;
  int         n_chk = 0;
  int         n_fail = 0;

  always #5 clk = ~clk;

  // behavioural comparator: analogue input sits half an LSB above level
  assign cmp_hi = (level >= dac_code);

  sar_serial_seq u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .di(di),
    .cmp_hi(cmp_hi), .do_out(do_out), .do_oe(do_oe),
    .mux_sel(mux_sel), .dac_code(dac_code)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rise_e();
    sclk = 1'b1; tick(H);
  endtask

  task automatic fall_e();
    sclk = 1'b0; tick(H);
  endtask

  task automatic convert(input logic [7:0] lvl, input logic [1:0] mx,
                         input int nzero, input int abort_at);
    level = lvl;
    cs_n = 1'b0; tick(2);
    for (int z = 0; z < nzero; z++) begin
      di = 1'b0; rise_e(); fall_e();
      chk("R2 zero ignored, oe", int'(do_oe), 0);
    end
    di = 1'b1; rise_e(); fall_e();
    chk("R8 oe after start bit", int'(do_oe), 0);
    di = mx[1]; rise_e(); fall_e();
    chk("R8 oe between address bits", int'(do_oe), 0);
    di = mx[0]; rise_e();
    chk("R3 mux_sel", int'(mux_sel), int'(mx));
    chk("R8 oe after address", int'(do_oe), 0);
    di = 1'b0; fall_e();
    chk("R4 oe on", int'(do_oe), 1);
    chk("R4 leading zero", int'(do_out), 0);
    chk("R4 first trial", int'(dac_code), 8'h80);
    for (int k = 1; k <= 8; k++) begin
      rise_e(); fall_e();
      if (k == abort_at) begin
        cs_n = 1'b1; tick(3);
        chk("R10 abort oe", int'(do_oe), 0);
        chk("R10 abort dac", int'(dac_code), 0);
        chk("R10 abort mux", int'(mux_sel), 0);
        return;
      end
      chk("R6 msb-first bit", int'(do_out), int'(lvl[8-k]));
      if (k < 8)
        chk("R5 partial code", int'(dac_code),
            int'((lvl & (8'hFF << (8-k))) | (8'h01 << (7-k))));
    end
    chk("R5 final code", int'(dac_code), int'(lvl));
    chk("R3 mux held", int'(mux_sel), int'(mx));
    for (int k = 9; k <= 15; k++) begin
      rise_e(); fall_e();
      chk("R7 lsb-first bit", int'(do_out), int'(lvl[k-8]));
      chk("R7 oe during lsb stream", int'(do_oe), 1);
    end
    rise_e(); fall_e();
    chk("R7 release", int'(do_oe), 0);
    for (int e = 0; e < 3; e++) begin
      di = 1'b1; rise_e(); di = 1'b0; fall_e();
      chk("R9 no restart oe", int'(do_oe), 0);
      chk("R9 result kept", int'(dac_code), int'(lvl));
    end
    cs_n = 1'b1; tick(3);
    chk("R10 cleared oe", int'(do_oe), 0);
    chk("R10 cleared dac", int'(dac_code), 0);
    chk("R10 cleared mux", int'(mux_sel), 0);
  endtask

  initial begin
    rst_n = 1'b0; cs_n = 1'b0; sclk = 1'b0; di = 1'b0; level = 8'd0;
    tick(4);
    rst_n = 1'b1; tick(3);
    chk("R1 reset oe", int'(do_oe), 0);
    chk("R1 reset dac", int'(dac_code), 0);
    chk("R1 reset mux", int'(mux_sel), 0);
    for (int p = 0; p < 6; p++) begin
      di = 1'b1; rise_e(); fall_e();
    end
    chk("R1 no start without select edge, oe", int'(do_oe), 0);
    chk("R1 no start without select edge, mux", int'(mux_sel), 0);
    chk("R1 no start without select edge, dac", int'(dac_code), 0);
    cs_n = 1'b1; tick(3);
    for (int lv = 0; lv < 256; lv++)
      convert(8'(lv), 2'(lv % 4), lv % 3, 0);
    convert(8'hC3, 2'd1, 1, 3);  // R10 mid-search abort
    convert(8'hA5, 2'd2, 2, 0);  // R10 recovery
    convert(8'h01, 2'd3, 0, 8);  // R10 abort on final decision
    convert(8'hFE, 2'd0, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule